// File: doc/BRIEF.md
# Binary64 to Integer Converter with Selectable Overflow Policy

This unit turns an IEEE754 double-precision operand into an integer of one of four formats: 32-bit or 64-bit, signed or unsigned. A 3-bit mode chooses how values that do not fit are treated. There are two clamping policies. One maps NaN to the most negative value of the format and the other maps NaN to zero. The third policy wraps the rounded value modulo 2^N and maps NaN and the infinities to zero. The same mode field also decides whether rounding follows a supplied dynamic rounding mode or always truncates.

The datapath is combinational and has three stages. A decoder turns the mode into a policy and a rounding choice. A rounding stage produces the integer magnitude together with overflow and special-value markers. A policy stage applies clamping or wrap and extends the value to 64 bits. A single output register gives a latency of one clock. A 32-bit result is sign-extended when the target is signed and zero-extended when it is unsigned. Mode codes 110 and 111 are illegal: they raise an output flag and force a zero result.

Top module: `f2i_conv`

## Requirements
- R1: When `cvt_mode` is 3'b110 or 3'b111, `mode_bad` is 1 and `int_out` is 0 in the following cycle. For every other code, `mode_bad` is 0.
- R2: Even mode codes round with `dyn_rm`, where 00 is nearest-even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity. Odd mode codes always truncate toward zero.
- R3: Under codes 000 and 001 (clamp, NaN to minimum), a NaN operand gives the type minimum. That minimum is 0 for unsigned and -2^(N-1) for signed.
- R4: Under codes 010 and 011 (clamp, NaN to zero), a NaN operand gives 0.
- R5: Under both clamping policies, a rounded value above the type maximum gives the maximum, and one below the type minimum gives the minimum. The infinities are included. The maximum is 2^N-1 for unsigned and 2^(N-1)-1 for signed.
- R6: Under codes 100 and 101 (wrap), NaN and both infinities give 0.
- R7: Under wrap, any other operand is rounded and then reduced modulo 2^N. The low N bits of the result are read as the target type, so very large magnitudes give 0 in those bits.
- R8: `to_wide`=0 selects N=32. The upper 32 bits of `int_out` then copy bit 31 when `to_signed`=1 and are zero when `to_signed`=0. `to_wide`=1 selects N=64.
- R9: The result appears on `int_out` one clock after the inputs. During reset, `int_out` and `mode_bad` are 0.
- R10: Subnormal operands give 0, 1 or -1 as the rounding direction dictates, before the policy is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 64 | Binary64 operand |
| cvt_mode | input | 3 | Policy and rounding selector |
| dyn_rm | input | 2 | Dynamic rounding mode |
| to_signed | input | 1 | 1 selects a signed target |
| to_wide | input | 1 | 1 selects a 64-bit target, 0 a 32-bit target |
| int_out | output | 64 | Converted integer, registered |
| mode_bad | output | 1 | Illegal mode code seen, registered |

## Verification
Rounding and range handling can act on the same operand in the same cycle. An operand just below a format limit, such as 2^31-0.5 or 2^32-0.5, can round up past the limit. It must then be clamped, or wrapped to the low value, rather than come out as an unclamped number. The bench drives these half-way operands in every rounding mode, every format and every policy. It compares each registered output with a reference that rounds in real arithmetic and only then clamps or reduces modulo 2^N. Random operands with exponents near the format limits widen the coverage.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int SIG_W  = MAN_W + 1;
    localparam int INT_W  = 64;
    localparam int HALF_W = INT_W / 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int RWIN   = MAN_W + 3;

    typedef enum logic [1:0] {
        POL_CLAMP_MIN  = 2'd0,
        POL_CLAMP_ZERO = 2'd1,
        POL_WRAP       = 2'd2,
        POL_NONE       = 2'd3
    } policy_t;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_t;

    typedef struct packed {
        logic             neg;
        logic             nan;
        logic             inf;
        logic             big;
        logic [INT_W-1:0] mag;
    } magn_t;
endpackage

// File: rtl/f2i_decode.sv
module f2i_decode
    import f2i_pkg::*;
(
    input  logic [2:0] cvt_mode,
    input  logic [1:0] dyn_rm,
    output policy_t    pol,
    output rmode_t     rm,
    output logic       illegal
);
    always_comb begin
        pol     = POL_NONE;
        illegal = 1'b0;
        unique case (cvt_mode[2:1])
            2'b00: pol = POL_CLAMP_MIN;
            2'b01: pol = POL_CLAMP_ZERO;
            2'b10: pol = POL_WRAP;
            2'b11: begin
                pol     = POL_NONE;
                illegal = 1'b1;
            end
        endcase
        rm = cvt_mode[0] ? RM_ZERO : rmode_t'(dyn_rm);
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] fp_in,
    input  rmode_t          rm,
    output magn_t           q
);
    localparam logic [EXP_W-1:0] POINT    = EXP_W'(BIAS + MAN_W);
    localparam logic [EXP_W-1:0] BIG_SH   = EXP_W'(INT_W - MAN_W);
    localparam logic [EXP_W-1:0] SH_LIM   = EXP_W'(INT_W);
    localparam logic [EXP_W-1:0] RS_LIM   = EXP_W'(RWIN);

    logic                 sgn;
    logic [EXP_W-1:0]     ex;
    logic [MAN_W-1:0]     fr;
    logic                 ex_top;
    logic [SIG_W-1:0]     sig;
    logic [EXP_W-1:0]     lsh;
    logic [EXP_W-1:0]     rsh;
    logic [6:0]           lsh_c;
    logic [5:0]           rsh_c;
    logic [INT_W-1:0]     left_mag;
    logic [SIG_W+RWIN-1:0] win;
    logic [SIG_W-1:0]     ipart;
    logic                 guard;
    logic                 sticky;
    logic                 inc;
    logic                 left_side;

    assign sgn    = fp_in[FP_W-1];
    assign ex     = fp_in[FP_W-2:MAN_W];
    assign fr     = fp_in[MAN_W-1:0];
    assign ex_top = &ex;
    assign sig    = {|ex, fr};

    assign left_side = (ex >= POINT);
    assign lsh       = ex - POINT;
    assign rsh       = POINT - ex;
    assign lsh_c     = (lsh > SH_LIM) ? 7'(INT_W) : lsh[6:0];
    assign rsh_c     = (rsh > RS_LIM) ? 6'(RWIN) : rsh[5:0];

    assign left_mag = {{(INT_W-SIG_W){1'b0}}, sig} << lsh_c;
    assign win      = {sig, {RWIN{1'b0}}} >> rsh_c;
    assign ipart    = win[SIG_W+RWIN-1:RWIN];
    assign guard    = win[RWIN-1];
    assign sticky   = |win[RWIN-2:0];

    always_comb begin
        unique case (rm)
            RM_NEAR_EVEN: inc = guard & (sticky | ipart[0]);
            RM_ZERO:      inc = 1'b0;
            RM_UP:        inc = ~sgn & (guard | sticky);
            RM_DOWN:      inc = sgn & (guard | sticky);
        endcase
    end

    always_comb begin
        q.neg = sgn;
        q.nan = ex_top & (|fr);
        q.inf = ex_top & ~(|fr);
        if (left_side) begin
            q.mag = left_mag;
            q.big = ex_top | (lsh >= BIG_SH);
        end else begin
            q.mag = {{(INT_W-SIG_W){1'b0}}, ipart} + {{(INT_W-1){1'b0}}, inc};
            q.big = 1'b0;
        end
    end
endmodule

// File: rtl/f2i_policy.sv
module f2i_policy
    import f2i_pkg::*;
(
    input  magn_t            q,
    input  policy_t          pol,
    input  logic             to_signed,
    input  logic             to_wide,
    output logic [INT_W-1:0] res
);
    logic             over_pos;
    logic             over_neg;
    logic [INT_W-1:0] max_val;
    logic [INT_W-1:0] min_val;
    logic [INT_W-1:0] wrapped;
    logic [INT_W-1:0] negated;

    assign negated = -q.mag;
    assign wrapped = q.neg ? negated : q.mag;

    always_comb begin
        if (to_wide) begin
            over_pos = to_signed ? q.mag[INT_W-1] : 1'b0;
            over_neg = q.mag[INT_W-1] & (|q.mag[INT_W-2:0]);
            max_val  = to_signed ? {1'b0, {(INT_W-1){1'b1}}} : {INT_W{1'b1}};
            min_val  = to_signed ? {1'b1, {(INT_W-1){1'b0}}} : '0;
        end else begin
            over_pos = to_signed ? (|q.mag[INT_W-1:HALF_W-1]) : (|q.mag[INT_W-1:HALF_W]);
            over_neg = (|q.mag[INT_W-1:HALF_W]) |
                       (q.mag[HALF_W-1] & (|q.mag[HALF_W-2:0]));
            max_val  = to_signed ? {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}}
                                 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
            min_val  = to_signed ? {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}} : '0;
        end
    end

    always_comb begin
        res = '0;
        unique case (pol)
            POL_CLAMP_MIN, POL_CLAMP_ZERO: begin
                if (q.nan)
                    res = (pol == POL_CLAMP_MIN) ? min_val : '0;
                else if (!q.neg)
                    res = (q.big | over_pos) ? max_val : q.mag;
                else if (!to_signed)
                    res = '0;
                else
                    res = (q.big | over_neg) ? min_val : negated;
            end
            POL_WRAP: begin
                if (q.nan | q.inf)
                    res = '0;
                else if (to_wide)
                    res = wrapped;
                else if (to_signed)
                    res = {{HALF_W{wrapped[HALF_W-1]}}, wrapped[HALF_W-1:0]};
                else
                    res = {{HALF_W{1'b0}}, wrapped[HALF_W-1:0]};
            end
            POL_NONE: res = '0;
        endcase
    end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  fp_in,
    input  logic [2:0]       cvt_mode,
    input  logic [1:0]       dyn_rm,
    input  logic             to_signed,
    input  logic             to_wide,
    output logic [INT_W-1:0] int_out,
    output logic             mode_bad
);
    policy_t          pol;
    rmode_t           rm;
    logic             illegal;
    magn_t            q;
    logic [INT_W-1:0] res;

    f2i_decode u_dec (
        .cvt_mode (cvt_mode),
        .dyn_rm   (dyn_rm),
        .pol      (pol),
        .rm       (rm),
        .illegal  (illegal)
    );

    f2i_round u_rnd (
        .fp_in (fp_in),
        .rm    (rm),
        .q     (q)
    );

    f2i_policy u_pol (
        .q         (q),
        .pol       (pol),
        .to_signed (to_signed),
        .to_wide   (to_wide),
        .res       (res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_out  <= '0;
            mode_bad <= 1'b0;
        end else begin
            int_out  <= illegal ? '0 : res;
            mode_bad <= illegal;
        end
    end

    logic in_nan;
    logic in_inf;
    assign in_nan = (&fp_in[FP_W-2:MAN_W]) & (|fp_in[MAN_W-1:0]);
    assign in_inf = (&fp_in[FP_W-2:MAN_W]) & ~(|fp_in[MAN_W-1:0]);

    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_mode[2:1] == 2'b11) |=> (mode_bad && int_out == '0)); // R1
    AST_LEGAL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_mode[2:1] != 2'b11) |=> !mode_bad); // R1
    AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_nan && cvt_mode[2:1] == 2'b01) |=> (int_out == '0)); // R4
    AST_WRAP_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_nan || in_inf) && cvt_mode[2:1] == 2'b10) |=> (int_out == '0)); // R6
    AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_wide && !to_signed) |=> (int_out[INT_W-1:HALF_W] == '0)); // R8
    AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_wide && to_signed) |=>
        (int_out[INT_W-1:HALF_W] == {HALF_W{int_out[HALF_W-1]}})); // R8
    AST_POS_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_inf && !fp_in[FP_W-1] && !cvt_mode[2] && to_wide && !to_signed)
        |=> (int_out == {INT_W{1'b1}})); // R5
endmodule

// File: tb/tb_f2i_conv.sv
module tb_f2i_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] fp_in = '0;
    logic [2:0]  cvt_mode = '0;
    logic [1:0]  dyn_rm = '0;
    logic        to_signed = 1'b0;
    logic        to_wide = 1'b0;
    logic [63:0] int_out;
    logic        mode_bad;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    f2i_conv dut (
        .clk (clk), .rst_n (rst_n), .fp_in (fp_in), .cvt_mode (cvt_mode),
        .dyn_rm (dyn_rm), .to_signed (to_signed), .to_wide (to_wide),
        .int_out (int_out), .mode_bad (mode_bad)
    );

    function automatic real rnd_real(input real v, input logic [1:0] rm);
        real f, d;
        case (rm)
            2'd1: return (v >= 0.0) ? $floor(v) : $ceil(v);
            2'd2: return $ceil(v);
            2'd3: return $floor(v);
            default: begin
                f = $floor(v);
                d = v - f;
                if (d > 0.5) return f + 1.0;
                if (d < 0.5) return f;
                return ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
            end
        endcase
    endfunction

    function automatic logic [63:0] to_u64(input real r);
        real t = 9223372036854775808.0;
        longint li;
        if (r >= t) begin
            li = longint'(r - t);
            return {1'b1, li[62:0]};
        end
        li = longint'(r);
        return li;
    endfunction

    function automatic logic [63:0] ref_conv(input logic [63:0] op, input logic [2:0] md,
                                             input logic [1:0] rmd, input logic sg,
                                             input logic wd);
        bit nan = (&op[62:52]) && (|op[51:0]);
        bit inf = (&op[62:52]) && !(|op[51:0]);
        int n = wd ? 64 : 32;
        real two_n = 2.0 ** n;
        real half_n = 2.0 ** (n - 1);
        real v, r, a, k, m;
        logic [1:0] rm = md[0] ? 2'd1 : rmd;
        logic [63:0] mx, mn, b;
        if (md[2:1] == 2'b11) return '0;
        mx = sg ? ((64'd1 << (n - 1)) - 64'd1) : (wd ? '1 : 64'h0000_0000_FFFF_FFFF);
        mn = sg ? -(64'd1 << (n - 1)) : '0;
        v = $bitstoreal(op);
        if (md[2]) begin
            if (nan || inf) return '0;
            r = rnd_real(v, rm);
            a = (r < 0.0) ? -r : r;
            k = $floor(a / two_n);
            m = a - k * two_n;
            b = to_u64(m);
            if (r < 0.0) b = -b;
            if (!wd) b = sg ? {{32{b[31]}}, b[31:0]} : {32'b0, b[31:0]};
            return b;
        end
        if (nan) return (md[2:1] == 2'b00) ? mn : '0;
        r = inf ? v : rnd_real(v, rm);
        if (sg) begin
            if (r >= half_n) return mx;
            if (r < -half_n) return mn;
            return longint'(r);
        end
        if (r >= two_n) return mx;
        if (r <= 0.0) return '0;
        return to_u64(r);
    endfunction

    function automatic string tag_of(input logic [63:0] op, input logic [2:0] md,
                                     input logic [1:0] rmd, input logic wd);
        bit nan = (&op[62:52]) && (|op[51:0]);
        bit inf = (&op[62:52]) && !(|op[51:0]);
        real v = $bitstoreal(op);
        if (md[2:1] == 2'b11) return "R1";
        if (nan) return (md[2:1] == 2'b00) ? "R3" : (md[2:1] == 2'b01) ? "R4" : "R6";
        if (inf) return md[2] ? "R6" : "R5";
        if (op[62:52] == 0 && op[51:0] != 0) return "R10";
        if (md[2]) return "R7";
        if (v >= 2147483647.0 || v <= -2147483648.0) return "R5";
        if (!wd) return "R8";
        return (!md[0] && rmd != 2'd1) ? "R2" : "R2";
    endfunction

    task automatic apply(input logic [63:0] op, input logic [2:0] md, input logic [1:0] rmd,
                         input logic sg, input logic wd);
        logic [63:0] exp_v;
        logic exp_b;
        @(negedge clk);
        fp_in = op; cvt_mode = md; dyn_rm = rmd; to_signed = sg; to_wide = wd;
        exp_v = ref_conv(op, md, rmd, sg, wd);
        exp_b = (md[2:1] == 2'b11);
        @(posedge clk);
        #1;
        n_cmp++;
        if (int_out !== exp_v || mode_bad !== exp_b) begin
            n_bad++;
            $display("FAIL %s op=%h mode=%0d rm=%0d s=%0b w=%0b actual=%h/%0b expected=%h/%0b",
                     tag_of(op, md, rmd, wd), op, md, rmd, sg, wd, int_out, mode_bad,
                     exp_v, exp_b);
        end
    endtask

    logic [63:0] dirs [0:27];
    initial begin
        dirs[0]  = 64'h0000_0000_0000_0000; dirs[1]  = 64'h8000_0000_0000_0000;
        dirs[2]  = 64'h3FF0_0000_0000_0000; dirs[3]  = 64'hBFF0_0000_0000_0000;
        dirs[4]  = 64'h3FE0_0000_0000_0000; dirs[5]  = 64'hBFE0_0000_0000_0000;
        dirs[6]  = 64'h3FF8_0000_0000_0000; dirs[7]  = 64'h4004_0000_0000_0000;
        dirs[8]  = 64'hC004_0000_0000_0000; dirs[9]  = 64'h41E0_0000_0000_0000;
        dirs[10] = 64'h41DF_FFFF_FFC0_0000; dirs[11] = 64'h41DF_FFFF_FFE0_0000;
        dirs[12] = 64'hC1E0_0000_0000_0000; dirs[13] = 64'hC1E0_0000_0010_0000;
        dirs[14] = 64'h41EF_FFFF_FFF0_0000; dirs[15] = 64'h41F0_0000_0000_0000;
        dirs[16] = 64'h43E0_0000_0000_0000; dirs[17] = 64'hC3E0_0000_0000_0000;
        dirs[18] = 64'h43F0_0000_0000_0000; dirs[19] = 64'h7FEF_FFFF_FFFF_FFFF;
        dirs[20] = 64'hFFEF_FFFF_FFFF_FFFF; dirs[21] = 64'h7FF0_0000_0000_0000;
        dirs[22] = 64'hFFF0_0000_0000_0000; dirs[23] = 64'h7FF8_0000_0000_0000;
        dirs[24] = 64'hFFF0_0000_0000_0001; dirs[25] = 64'h0000_0000_0000_0001;
        dirs[26] = 64'h8000_0000_0000_0001; dirs[27] = 64'h4530_0000_0000_0001;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (int_out !== 64'd0 || mode_bad !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset state actual=%h/%0b expected=0/0", int_out, mode_bad);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 28; i++)
            for (int md = 0; md < 8; md++)
                for (int f = 0; f < 4; f++)
                    for (int rr = 0; rr < 4; rr++)
                        apply(dirs[i], 3'(md), 2'(rr), f[0], f[1]);
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] op;
            op = {$urandom, $urandom};
            if (i % 2 == 0) op[62:52] = 11'(1000 + ($urandom % 100));
            apply(op, 3'($urandom % 8), 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule